// File: doc/BRIEF.md
# SCSI Target Bus Acquisition and Reselection

This block lets a SCSI target win an 8-bit bus and reconnect to a host so that an operation it had disconnected from can resume. When asked to reconnect, it watches the sampled BSY, SEL and RST lines until the bus has been idle for a settle interval. It then claims BSY together with its own ID bit. After an arbitration window it checks whether any device with a higher ID is also on the bus. If none is, it asserts SEL and runs the reselection handshake with the chosen host.

The block drives only enable signals: BSY, SEL, I/O and one enable per data line. External open-collector drivers turn those enables into the wired bus. Three flags report how an attempt ended. A one-cycle pulse reports a lost arbitration, after which the block waits for the next bus-free interval. A held flag reports a connection made. Another held flag reports that the host did not respond. Every interval is a parameter in clock cycles. The defaults match 800 ns, 2.4 us and 250 ms at 100 MHz. A bus reset overrides everything.

Top module: `scsi_resel_acq`

## Requirements
- R1: The bus counts as free only while BSY, SEL and RST are all low. BSY is claimed only after FREE_DLY_CYC consecutive free cycles. In the bench this is between FREE_DLY_CYC and FREE_DLY_CYC+2 cycles after the bus frees with a request pending.
- R2: During arbitration the block drives BSY and only data bit k, where k is the own ID. It does not drive SEL or I/O.
- R3: After ARB_DLY_CYC cycles of arbitration, any data bit above the own ID makes the block lose. A higher numeric ID has the higher priority. On losing, the block releases all lines, pulses lost_o for one cycle, and claims BSY again only after a new free interval.
- R4: Data bits below the own ID do not cause a loss. The block wins and adds SEL to BSY.
- R5: One cycle after winning, the block asserts I/O and drives exactly the own and host ID bits with SEL still held. One cycle later it releases BSY.
- R6: When the host asserts BSY, the block drives BSY for one cycle with SEL, I/O and the ID bits still held. It then releases SEL and the data bits, keeps BSY and I/O, and raises done_o.
- R7: If host BSY has not appeared RSP_TMO_CYC cycles after the win, the block releases the data lines but keeps SEL and I/O, and samples BSY once more. If BSY is still absent, it releases every line and raises timeout_o.
- R8: A host BSY seen in that final sampling cycle still completes the connection with done_o.
- R9: After a timeout, the block makes no new attempt while the request stays high.
- R10: Bus RST high in any state releases all enables and clears all flags by the next cycle, and the block returns to idle. After chip reset all outputs are low.
- R11: done_o and timeout_o stay high until the reconnect request drops. The cycle after it drops, all lines and flags are released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low chip reset |
| bus_bsy_i | input | 1 | Sampled BSY line (wired-OR of all devices) |
| bus_sel_i | input | 1 | Sampled SEL line |
| bus_rst_i | input | 1 | Sampled bus RST line |
| bus_data_i | input | 8 | Sampled data lines, bit k is ID k |
| own_id_i | input | 3 | This target's ID |
| host_id_i | input | 3 | ID of the host to reselect |
| reconnect_req_i | input | 1 | Request to acquire the bus and reselect |
| bsy_oe_o | output | 1 | Drive enable for BSY |
| sel_oe_o | output | 1 | Drive enable for SEL |
| io_oe_o | output | 1 | Drive enable for I/O |
| data_oe_o | output | 8 | Drive enables for the data lines |
| done_o | output | 1 | Host connected (held) |
| lost_o | output | 1 | Arbitration lost (one-cycle pulse) |
| timeout_o | output | 1 | Host did not answer (held) |

## Verification
A wrong internal state shows at the ports almost at once, because every enable is decoded straight from the state register. A state that is too early or stuck shows as BSY claimed before the settle interval ends, or as SEL appearing while a higher ID bit is present. A corrupted response counter shows as a timeout that fires outside a window of one or two cycles around RSP_TMO_CYC. A missed priority or bus-reset decision shows as a driven line one cycle after the bus should have been released. The bench therefore measures each interval in cycles from the moment the bus frees or the win occurs. It checks the full set of enables at each handshake step and matches every done, lost and timeout flag against the ordered outcome it expected.

// File: rtl/scsi_acq_pkg.sv
package scsi_acq_pkg;
  localparam int ID_W   = 3;
  localparam int DATA_W = 1 << ID_W;

  typedef enum logic [3:0] {
    ST_IDLE, ST_WAITFREE, ST_ARB, ST_LOST, ST_SELECT, ST_RESEL_DRV,
    ST_RESEL_WAIT, ST_RECHECK, ST_HOLD, ST_CONN, ST_TMO
  } acq_st_e;

  // one-hot data-bus pattern that stands for a device ID
  function automatic logic [DATA_W-1:0] id_bit(input logic [ID_W-1:0] id);
    logic [DATA_W-1:0] v;
    v = '0;
    v[id] = 1'b1;
    return v;
  endfunction

  // pattern placed on the data lines during reselection
  function automatic logic [DATA_W-1:0] resel_mask(input logic [ID_W-1:0] own,
                                                   input logic [ID_W-1:0] host);
    return id_bit(own) | id_bit(host);
  endfunction
endpackage

// File: rtl/acq_cycle_ctr.sv
module acq_cycle_ctr #(
  parameter int unsigned LIMIT = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  input  logic en_i,
  output logic hit_o
);
  localparam int unsigned CW = (LIMIT > 1) ? $clog2(LIMIT) : 1;
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt_q;

  assign hit_o = en_i && (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt_q <= '0;
    else if (clr_i)      cnt_q <= '0;
    else if (en_i)       cnt_q <= hit_o ? '0 : cnt_q + 1'b1;
  end

  // R7
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);
endmodule

// File: rtl/acq_prio_chk.sv
module acq_prio_chk
  import scsi_acq_pkg::*;
(
  input  logic [DATA_W-1:0] bus_data_i,
  input  logic [ID_W-1:0]   own_id_i,
  output logic              lose_o
);
  logic [DATA_W-1:0] above;

  for (genvar g = 0; g < DATA_W; g++) begin : g_bit
    assign above[g] = bus_data_i[g] && (ID_W'(g) > own_id_i);
  end

  assign lose_o = |above;
endmodule

// File: rtl/scsi_resel_acq.sv
module scsi_resel_acq
  import scsi_acq_pkg::*;
#(
  parameter int unsigned FREE_DLY_CYC = 80,
  parameter int unsigned ARB_DLY_CYC  = 240,
  parameter int unsigned RSP_TMO_CYC  = 25_000_000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_bsy_i,
  input  logic              bus_sel_i,
  input  logic              bus_rst_i,
  input  logic [DATA_W-1:0] bus_data_i,
  input  logic [ID_W-1:0]   own_id_i,
  input  logic [ID_W-1:0]   host_id_i,
  input  logic              reconnect_req_i,
  output logic              bsy_oe_o,
  output logic              sel_oe_o,
  output logic              io_oe_o,
  output logic [DATA_W-1:0] data_oe_o,
  output logic              done_o,
  output logic              lost_o,
  output logic              timeout_o
);
  acq_st_e st_q, st_d;

  // named internal events
  logic bus_free, free_hit, arb_hit, rsp_hit, lose_seen, rsp_window;

  assign bus_free   = !bus_bsy_i && !bus_sel_i && !bus_rst_i;
  assign rsp_window = (st_q == ST_SELECT) || (st_q == ST_RESEL_DRV) ||
                      (st_q == ST_RESEL_WAIT);

  acq_cycle_ctr #(.LIMIT(FREE_DLY_CYC)) u_free_ctr (
    .clk(clk), .rst_n(rst_n),
    .clr_i(!(st_q == ST_WAITFREE && bus_free)),
    .en_i(st_q == ST_WAITFREE && bus_free),
    .hit_o(free_hit));

  acq_cycle_ctr #(.LIMIT(ARB_DLY_CYC)) u_arb_ctr (
    .clk(clk), .rst_n(rst_n),
    .clr_i(st_q != ST_ARB),
    .en_i(st_q == ST_ARB),
    .hit_o(arb_hit));

  acq_cycle_ctr #(.LIMIT(RSP_TMO_CYC)) u_rsp_ctr (
    .clk(clk), .rst_n(rst_n),
    .clr_i(!rsp_window),
    .en_i(rsp_window),
    .hit_o(rsp_hit));

  acq_prio_chk u_prio (
    .bus_data_i(bus_data_i), .own_id_i(own_id_i), .lose_o(lose_seen));

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE:       if (reconnect_req_i) st_d = ST_WAITFREE;
      ST_WAITFREE:   if (!reconnect_req_i) st_d = ST_IDLE;
                     else if (free_hit) st_d = ST_ARB;
      ST_ARB:        if (arb_hit) st_d = lose_seen ? ST_LOST : ST_SELECT;
      ST_LOST:       st_d = ST_WAITFREE;
      ST_SELECT:     st_d = ST_RESEL_DRV;
      ST_RESEL_DRV:  st_d = ST_RESEL_WAIT;
      ST_RESEL_WAIT: if (bus_bsy_i) st_d = ST_HOLD;
                     else if (rsp_hit) st_d = ST_RECHECK;
      ST_RECHECK:    st_d = bus_bsy_i ? ST_HOLD : ST_TMO;
      ST_HOLD:       st_d = ST_CONN;
      ST_CONN:       if (!reconnect_req_i) st_d = ST_IDLE;
      ST_TMO:        if (!reconnect_req_i) st_d = ST_IDLE;
      default:       st_d = ST_IDLE;
    endcase
    if (bus_rst_i) st_d = ST_IDLE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end

  always_comb begin
    bsy_oe_o  = 1'b0;
    sel_oe_o  = 1'b0;
    io_oe_o   = 1'b0;
    data_oe_o = '0;
    done_o    = 1'b0;
    lost_o    = 1'b0;
    timeout_o = 1'b0;
    unique case (st_q)
      ST_ARB:       begin bsy_oe_o = 1'b1; data_oe_o = id_bit(own_id_i); end
      ST_SELECT:    begin bsy_oe_o = 1'b1; sel_oe_o = 1'b1;
                          data_oe_o = id_bit(own_id_i); end
      ST_RESEL_DRV: begin bsy_oe_o = 1'b1; sel_oe_o = 1'b1; io_oe_o = 1'b1;
                          data_oe_o = resel_mask(own_id_i, host_id_i); end
      ST_RESEL_WAIT:begin sel_oe_o = 1'b1; io_oe_o = 1'b1;
                          data_oe_o = resel_mask(own_id_i, host_id_i); end
      ST_RECHECK:   begin sel_oe_o = 1'b1; io_oe_o = 1'b1; end
      ST_HOLD:      begin bsy_oe_o = 1'b1; sel_oe_o = 1'b1; io_oe_o = 1'b1;
                          data_oe_o = resel_mask(own_id_i, host_id_i); end
      ST_CONN:      begin bsy_oe_o = 1'b1; io_oe_o = 1'b1; done_o = 1'b1; end
      ST_LOST:      lost_o = 1'b1;
      ST_TMO:       timeout_o = 1'b1;
      default:      ;
    endcase
  end

  // R1
  free_before_claim_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(bsy_oe_o) && !sel_oe_o) |-> $past(!bus_bsy_i && !bus_sel_i && !bus_rst_i));

  // R2
  arb_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bsy_oe_o && !sel_oe_o && !io_oe_o) |-> (data_oe_o == id_bit(own_id_i)));

  // R3
  lost_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lost_o && !bus_rst_i) |=> (!lost_o && !bsy_oe_o && !sel_oe_o));

  // R4
  win_from_arb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sel_oe_o) |-> $past(bsy_oe_o) && !io_oe_o);

  // R5
  resel_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(bsy_oe_o) && sel_oe_o) |->
      (io_oe_o && data_oe_o == resel_mask(own_id_i, host_id_i)));

  // R6
  connect_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (bsy_oe_o && io_oe_o && !sel_oe_o && data_oe_o == '0));

  // R7
  recheck_then_tmo_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(timeout_o) |-> ($past(sel_oe_o) && $past(data_oe_o) == '0 &&
                          !bsy_oe_o && !sel_oe_o && !io_oe_o));

  // R10
  bus_rst_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rst_i |=> (!bsy_oe_o && !sel_oe_o && !io_oe_o && data_oe_o == '0 &&
                   !done_o && !timeout_o && !lost_o));
endmodule

// File: tb/test_scsi_resel_acq.sv
module test_scsi_resel_acq;
  localparam int FREE_DLY = 8;
  localparam int ARB_DLY  = 4;
  localparam int TMO      = 40;

  typedef enum int {EV_DONE, EV_LOST, EV_TMO} ev_e;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic       rst_n, req, host_bsy, oth_bsy, oth_sel, rst_line;
  logic [2:0] own, host;
  logic [7:0] oth_data;
  logic       bsy_oe, sel_oe, io_oe, done, lost, tmo;
  logic [7:0] data_oe;

  wire       bus_bsy  = bsy_oe | host_bsy | oth_bsy;
  wire       bus_sel  = sel_oe | oth_sel;
  wire [7:0] bus_data = data_oe | oth_data;

  scsi_resel_acq #(.FREE_DLY_CYC(FREE_DLY), .ARB_DLY_CYC(ARB_DLY),
                   .RSP_TMO_CYC(TMO)) i_scsi_resel_acq (
    .clk(clk), .rst_n(rst_n), .bus_bsy_i(bus_bsy), .bus_sel_i(bus_sel),
    .bus_rst_i(rst_line), .bus_data_i(bus_data), .own_id_i(own),
    .host_id_i(host), .reconnect_req_i(req), .bsy_oe_o(bsy_oe),
    .sel_oe_o(sel_oe), .io_oe_o(io_oe), .data_oe_o(data_oe),
    .done_o(done), .lost_o(lost), .timeout_o(tmo));

  int n_chk = 0, n_fail = 0, cyc = 0;
  bit finished = 0;
  ev_e exp_q[$];

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  // monitor: pop expected outcome on each flag rising edge
  logic pd = 0, pl = 0, pt = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (done && !pd) pop_cmp(EV_DONE, "R6");
      if (lost && !pl) pop_cmp(EV_LOST, "R3");
      if (tmo && !pt)  pop_cmp(EV_TMO, "R7");
    end
    pd <= done; pl <= lost; pt <= tmo;
  end

  task automatic pop_cmp(input ev_e got, input string tag);
    ev_e e;
    if (exp_q.size() == 0) chk(0, {tag, " unexpected outcome"}, int'(got), -1);
    else begin
      e = exp_q.pop_front();
      chk(e == got, {tag, " outcome order"}, int'(got), int'(e));
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !finished) begin
      finished = 1;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  task automatic wait_bsy(output int n);
    n = 0;
    while (!bsy_oe && n < 500) begin step(1); n++; end
  endtask

  task automatic wait_resel_wait();
    int g = 0;
    while (!(io_oe && !bsy_oe && sel_oe) && g < 500) begin step(1); g++; end
  endtask

  task automatic wait_done();
    int g = 0;
    while (!done && g < 500) begin step(1); g++; end
  endtask

  task automatic all_idle(input string tag);
    chk(!bsy_oe && !sel_oe && !io_oe && data_oe == 0, tag,
        {bsy_oe, sel_oe, io_oe, data_oe}, 0);
  endtask

  initial begin
    int n;
    bit bad;
    rst_n = 0; req = 0; host_bsy = 0; oth_bsy = 0; oth_sel = 0; rst_line = 0;
    oth_data = 0; own = 0; host = 0;
    step(3);
    all_idle("R10 reset state");
    chk(!done && !lost && !tmo, "R10 reset flags", {done, lost, tmo}, 0);
    rst_n = 1;
    step(2);

    // normal reconnection
    own = 5; host = 2; exp_q.push_back(EV_DONE);
    req = 1;
    wait_bsy(n);
    chk(n >= FREE_DLY && n <= FREE_DLY + 2, "R1 settle before BSY", n, FREE_DLY + 1);
    chk(data_oe == 8'h20 && !sel_oe && !io_oe, "R2 arbitration drive", data_oe, 8'h20);
    wait_resel_wait();
    chk(sel_oe && io_oe && data_oe == 8'h24, "R5 reselection pattern", data_oe, 8'h24);
    step(3);
    host_bsy = 1;
    wait_done();
    chk(bsy_oe && io_oe && !sel_oe && data_oe == 0, "R6 connected lines",
        {bsy_oe, io_oe, sel_oe, data_oe}, 11'h600);
    step(5);
    chk(done, "R11 done held", done, 1);
    req = 0;
    step(1);
    all_idle("R11 release after request drop");
    chk(!done, "R11 done cleared", done, 0);
    host_bsy = 0;
    step(3);

    // lose to a higher ID, then retry and win
    own = 2; host = 7; exp_q.push_back(EV_LOST);
    req = 1;
    wait_bsy(n);
    oth_bsy = 1; oth_data = 8'h40;
    n = 0;
    while (!lost && n < 50) begin step(1); n++; end
    chk(lost && !bsy_oe && data_oe == 0, "R3 released on loss", {lost, bsy_oe, data_oe}, 10'h200);
    bad = 0;
    for (int i = 0; i < 20; i++) begin step(1); if (bsy_oe) bad = 1; end
    chk(!bad, "R3 no claim while bus busy", bad, 0);
    exp_q.push_back(EV_DONE);
    oth_bsy = 0; oth_data = 0;
    wait_bsy(n);
    chk(n >= FREE_DLY && n <= FREE_DLY + 2, "R3 retry after free", n, FREE_DLY);
    wait_resel_wait();
    chk(data_oe == 8'h84, "R5 reselection pattern 2", data_oe, 8'h84);
    host_bsy = 1;
    wait_done();
    req = 0; step(1); host_bsy = 0; step(3);

    // lower ID present: still wins
    own = 4; host = 0; exp_q.push_back(EV_DONE);
    req = 1;
    wait_bsy(n);
    oth_bsy = 1; oth_data = 8'h02;
    n = 0;
    while (!sel_oe && n < 50) begin step(1); n++; end
    chk(sel_oe && bsy_oe && !lost, "R4 win over lower ID", {sel_oe, bsy_oe, lost}, 6);
    oth_bsy = 0; oth_data = 0;
    wait_resel_wait();
    host_bsy = 1;
    wait_done();
    req = 0; step(1); host_bsy = 0; step(3);

    // no host answer: timeout
    own = 3; host = 0; exp_q.push_back(EV_TMO);
    req = 1;
    n = 0;
    while (!sel_oe && n < 500) begin step(1); n++; end
    n = 0;
    while (!(sel_oe && data_oe == 0) && n < 500) begin step(1); n++; end
    chk(n >= TMO - 1 && n <= TMO + 1, "R7 response window", n, TMO);
    chk(sel_oe && io_oe && !bsy_oe, "R7 recheck keeps SEL and IO", {sel_oe, io_oe, bsy_oe}, 6);
    step(1);
    chk(tmo, "R7 timeout flag", tmo, 1);
    all_idle("R7 lines released on timeout");
    bad = 0;
    for (int i = 0; i < 50; i++) begin step(1); if (bsy_oe || sel_oe) bad = 1; end
    chk(!bad, "R9 no retry after timeout", bad, 0);
    chk(tmo, "R11 timeout held", tmo, 1);
    req = 0;
    step(1);
    chk(!tmo, "R11 timeout cleared", tmo, 0);
    step(2);

    // host answers during the final sampling cycle
    own = 6; host = 1; exp_q.push_back(EV_DONE);
    req = 1;
    n = 0;
    while (!(sel_oe && io_oe && data_oe == 0) && n < 500) begin step(1); n++; end
    host_bsy = 1;
    step(2);
    chk(done && !tmo, "R8 late answer connects", {done, tmo}, 2);
    req = 0; step(1); host_bsy = 0; step(3);

    // busy lines and bus reset hold off arbitration
    own = 0; host = 7;
    oth_sel = 1; req = 1;
    bad = 0;
    for (int i = 0; i < 30; i++) begin step(1); if (bsy_oe) bad = 1; end
    chk(!bad, "R1 SEL alone blocks", bad, 0);
    oth_sel = 0; rst_line = 1;
    bad = 0;
    for (int i = 0; i < 30; i++) begin step(1); if (bsy_oe) bad = 1; end
    chk(!bad, "R1 RST blocks", bad, 0);
    rst_line = 0;
    wait_bsy(n);
    chk(n >= FREE_DLY && n <= FREE_DLY + 2, "R1 settle after RST", n, FREE_DLY + 1);
    step(1);
    rst_line = 1;
    step(1);
    all_idle("R10 bus reset in arbitration");
    rst_line = 0; req = 0; step(3);

    // bus reset while waiting for the host
    own = 1; host = 5;
    req = 1;
    wait_resel_wait();
    rst_line = 1;
    step(1);
    all_idle("R10 bus reset in reselection");
    chk(!done && !tmo, "R10 no flag after reset", {done, tmo}, 0);
    req = 0; rst_line = 0;
    step(5);

    chk(exp_q.size() == 0, "R6 scoreboard drained", exp_q.size(), 0);
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule